// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles conditional control transfers for a small 16-bit load/store processor. For each request it receives the current program counter, the register value to be tested, a register-held target address and the instruction word. It first latches the outcome of the test into a one-bit condition register. Only after that does it form the next program counter. Forming the next PC takes a sequence of steps that depends on the instruction.

There are two ways to obtain the target. In the register-target mode the target is taken from a register, and one variant also hands the return address back for writing into the register file. In the PC-relative mode the PC is copied into a buffer, and the sign-extended 8-bit displacement from the instruction is added to it. The processor's sequencer raises `start` once the operands are valid. It then takes the new PC from `nextPc` when `done` pulses, and performs the register write whenever `linkWe` is high.

Top module: `branch_resolver`

## Requirements
- R1: After reset, `nextPc` is 0 and `done`, `taken` and `linkWe` are all 0.
- R2: The opcode sits in `instrWord[15:11]` and the displacement in `instrWord[7:0]`. The PC-relative conditions are: opcode 19 taken when `testVal` is all zero; opcode 18 taken when it is non-zero; opcode 16 taken when bit 15 is 0; opcode 17 taken when bit 15 is 1. When a PC-relative branch is taken, `nextPc` becomes `pcIn` plus the displacement. `done` is high in the fifth cycle after the edge at which `start` is sampled.
- R3: The displacement is sign extended by copying bit 7 into bits 15..8. The sum wraps modulo 2^16.
- R4: Opcode 20 (register target) is taken when `testVal` is zero, and it then loads `targetVal` into `nextPc`. `done` is high in the third cycle after the start edge.
- R5: Opcode 21 (register target with link) behaves as opcode 20. In addition, whatever the test result, it raises `linkWe` for exactly one cycle, the second cycle after the start edge, with `linkData` equal to `pcIn`. `done` follows in the fourth cycle.
- R6: When a supported branch is not taken, `done` still pulses, `taken` is 0 and `nextPc` equals `pcIn`.
- R7: Any opcode other than 16 to 21 clears the condition. It leaves `nextPc` at `pcIn`, never raises `linkWe`, and pulses `done` in the third cycle after the start edge.
- R8: `done` is a single-cycle pulse, and `taken` is high only in the `done` cycle.
- R9: `start` is ignored while a resolution is in progress, including the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a resolution with the operands presented this cycle |
| instrWord | input | 16 | Instruction word (opcode and displacement) |
| pcIn | input | 16 | Current program counter |
| testVal | input | 16 | Register value to test |
| targetVal | input | 16 | Register-held target address |
| nextPc | output | 16 | Resolved program counter |
| taken | output | 1 | Branch taken, valid with `done` |
| done | output | 1 | One-cycle end-of-resolution pulse |
| linkWe | output | 1 | Return-address write request |
| linkData | output | 16 | Return address to write |

## Verification
The bench builds the block with its default widths: a 16-bit datapath, an 8-bit displacement and a 5-bit opcode field. With these widths it can drive the sign bit, the all-zero boundary and displacement wrap past both ends of the address space directly. A behavioural model predicts, cycle by cycle, the step count for each mode, where the link write falls, and the PC outcome, and every output is compared against it. The model is fed every condition polarity, positive, negative and extreme displacements, unsupported opcodes, and a `start` held high across a busy resolution.

// File: rtl/brres_pkg.sv
package brres_pkg;
  localparam int DATA_W = 16;
  localparam int DISP_W = 8;
  localparam int OPC_W  = 5;

  localparam logic [OPC_W-1:0] OPC_JPOS  = 5'd16;
  localparam logic [OPC_W-1:0] OPC_JNEG  = 5'd17;
  localparam logic [OPC_W-1:0] OPC_JNZ   = 5'd18;
  localparam logic [OPC_W-1:0] OPC_JZ    = 5'd19;
  localparam logic [OPC_W-1:0] OPC_RZ    = 5'd20;
  localparam logic [OPC_W-1:0] OPC_RZL   = 5'd21;

  typedef struct packed {
    logic capture;
    logic setCon;
    logic link;
    logic loadBuf;
    logic addDisp;
    logic update;
    logic selRel;
    logic done;
  } ctlStrobes_t;
endpackage

// File: rtl/brres_ctrl.sv
module brres_ctrl
  import brres_pkg::*;
#(
  parameter int OPCW = OPC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [OPCW-1:0] opCode,
  output ctlStrobes_t     st
);
  typedef enum logic [2:0] {
    S_IDLE, S_TEST, S_LINK, S_BUF, S_ADD, S_UPD, S_DONE
  } state_t;

  state_t state, stateNext;
  logic isRel, isLink;

  assign isRel  = (opCode == OPC_JZ) || (opCode == OPC_JNZ) ||
                  (opCode == OPC_JPOS) || (opCode == OPC_JNEG);
  assign isLink = (opCode == OPC_RZL);

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: if (start) stateNext = S_TEST;
      S_TEST: begin
        if (isLink)     stateNext = S_LINK;
        else if (isRel) stateNext = S_BUF;
        else            stateNext = S_UPD;
      end
      S_LINK: stateNext = S_UPD;
      S_BUF:  stateNext = S_ADD;
      S_ADD:  stateNext = S_UPD;
      S_UPD:  stateNext = S_DONE;
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    st         = '0;
    st.capture = (state == S_IDLE) && start;
    st.setCon  = (state == S_TEST);
    st.link    = (state == S_LINK);
    st.loadBuf = (state == S_BUF);
    st.addDisp = (state == S_ADD);
    st.update  = (state == S_UPD);
    st.selRel  = isRel;
    st.done    = (state == S_DONE);
  end
endmodule

// File: rtl/brres_dpath.sv
module brres_dpath
  import brres_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int DSPW = DISP_W,
  parameter int OPCW = OPC_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     st,
  input  logic [DW-1:0]   instrWord,
  input  logic [DW-1:0]   pcIn,
  input  logic [DW-1:0]   testVal,
  input  logic [DW-1:0]   targetVal,
  output logic [OPCW-1:0] opCode,
  output logic [DW-1:0]   nextPc,
  output logic            taken,
  output logic            linkWe,
  output logic [DW-1:0]   linkData
);
  localparam int OPC_LSB = DW - OPCW;
  localparam int EXT_W   = DW - DSPW;

  logic [DW-1:0]   pcReg, testReg, tgtReg, bufA, sumReg;
  logic [DSPW-1:0] dispReg;
  logic [OPCW-1:0] opReg;
  logic            conReg, conNext;
  logic [DW-1:0]   dispExt;

  assign dispExt = {{EXT_W{dispReg[DSPW-1]}}, dispReg};

  always_comb begin
    unique case (opReg)
      OPC_JZ, OPC_RZ, OPC_RZL: conNext = (testReg == '0);
      OPC_JNZ:                 conNext = (testReg != '0);
      OPC_JPOS:                conNext = ~testReg[DW-1];
      OPC_JNEG:                conNext = testReg[DW-1];
      default:                 conNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg   <= '0;
      testReg <= '0;
      tgtReg  <= '0;
      bufA    <= '0;
      sumReg  <= '0;
      dispReg <= '0;
      opReg   <= '0;
      conReg  <= 1'b0;
    end else begin
      if (st.capture) begin
        pcReg   <= pcIn;
        testReg <= testVal;
        tgtReg  <= targetVal;
        dispReg <= instrWord[DSPW-1:0];
        opReg   <= instrWord[DW-1:OPC_LSB];
      end
      if (st.setCon)  conReg <= conNext;
      if (st.loadBuf) bufA   <= pcReg;
      if (st.addDisp) sumReg <= bufA + dispExt;
      if (st.update && conReg) pcReg <= st.selRel ? sumReg : tgtReg;
    end
  end

  assign opCode   = opReg;
  assign nextPc   = pcReg;
  assign taken    = st.done & conReg;
  assign linkWe   = st.link;
  assign linkData = pcReg;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import brres_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] instrWord,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] testVal,
  input  logic [DATA_W-1:0] targetVal,
  output logic [DATA_W-1:0] nextPc,
  output logic              taken,
  output logic              done,
  output logic              linkWe,
  output logic [DATA_W-1:0] linkData
);
  ctlStrobes_t      st;
  logic [OPC_W-1:0] opCode;

  brres_ctrl #(.OPCW(OPC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .st(st)
  );

  brres_dpath #(.DW(DATA_W), .DSPW(DISP_W), .OPCW(OPC_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .instrWord(instrWord), .pcIn(pcIn),
    .testVal(testVal), .targetVal(targetVal), .opCode(opCode),
    .nextPc(nextPc), .taken(taken), .linkWe(linkWe), .linkData(linkData)
  );

  assign done = st.done;
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk (
  input logic        clk,
  input logic        rstN,
  input logic        done,
  input logic        taken,
  input logic        linkWe,
  input logic [15:0] nextPc
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_taken_with_done: assert property (@(posedge clk) disable iff (!rstN)
    taken |-> done);

  a_r5_link_single: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |=> !linkWe);

  a_r5_link_before_done: assert property (@(posedge clk) disable iff (!rstN)
    linkWe |=> !done ##1 done);

  a_r6_pc_kept_when_not_taken: assert property (@(posedge clk) disable iff (!rstN)
    (done && !taken) |-> $stable(nextPc));

  a_r5_no_link_with_done: assert property (@(posedge clk) disable iff (!rstN)
    !(linkWe && done));
endmodule

bind branch_resolver branch_resolver_chk chk (
  .clk(clk), .rstN(rstN), .done(done), .taken(taken),
  .linkWe(linkWe), .nextPc(nextPc)
);

// File: tb/branch_resolver_test.sv
module branch_resolver_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instrWord = '0, pcIn = '0, testVal = '0, targetVal = '0;
  logic [15:0] nextPc, linkData;
  logic        taken, done, linkWe;

  int compared = 0, mismatched = 0;
  string curTag = "R1";

  always #4 clk = ~clk;

  branch_resolver uut (
    .clk(clk), .rstN(rstN), .start(start), .instrWord(instrWord),
    .pcIn(pcIn), .testVal(testVal), .targetVal(targetVal),
    .nextPc(nextPc), .taken(taken), .done(done),
    .linkWe(linkWe), .linkData(linkData)
  );

  // reference model, stepped per clock
  int          mStep = 0, mLen = 0, mLinkAt = 0;
  logic        mWill = 1'b0;
  logic [15:0] mPc = '0, mTgt = '0, mLinkPc = '0;
  logic        mDone = 1'b0, mTaken = 1'b0, mLink = 1'b0;
  int          doneCount = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mStep = 0; mPc = '0; mDone = 0; mTaken = 0; mLink = 0;
    end else begin
      mDone = 0; mTaken = 0; mLink = 0;
      if (mStep == 0) begin
        if (start) begin
          int opc;
          logic [15:0] dsp;
          opc = int'(instrWord[15:11]);
          dsp = {{8{instrWord[7]}}, instrWord[7:0]};
          mPc = pcIn; mLinkPc = pcIn; mLinkAt = 0;
          case (opc)
            19: begin mLen = 5; mWill = (testVal == 0);   mTgt = pcIn + dsp; end
            18: begin mLen = 5; mWill = (testVal != 0);   mTgt = pcIn + dsp; end
            16: begin mLen = 5; mWill = (testVal[15] == 0); mTgt = pcIn + dsp; end
            17: begin mLen = 5; mWill = (testVal[15] == 1); mTgt = pcIn + dsp; end
            20: begin mLen = 3; mWill = (testVal == 0); mTgt = targetVal; end
            21: begin mLen = 4; mWill = (testVal == 0); mTgt = targetVal; mLinkAt = 2; end
            default: begin mLen = 3; mWill = 0; mTgt = pcIn; end
          endcase
          mStep = 1;
        end
      end else if (mStep == mLen) begin
        mStep = 0;
      end else begin
        mStep = mStep + 1;
        if (mStep == mLinkAt) mLink = 1;
        if (mStep == mLen) begin
          mDone = 1; mTaken = mWill;
          if (mWill) mPc = mTgt;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp,
                       input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      check(curTag, nextPc, mPc, "nextPc");
      check(curTag, {15'd0, done}, {15'd0, mDone}, "done");
      check("R8", {15'd0, taken}, {15'd0, mTaken}, "taken");
      check(curTag, {15'd0, linkWe}, {15'd0, mLink}, "linkWe");
      if (mLink) check("R5", linkData, mLinkPc, "linkData");
      if (done) doneCount++;
    end
  end

  task automatic runOp(input string tag, input int opc, input logic [7:0] dsp,
                       input logic [15:0] pc, input logic [15:0] tv,
                       input logic [15:0] tg, input int holdCycles);
    curTag = tag;
    doneCount = 0;
    @(negedge clk);
    instrWord = {opc[4:0], 3'b000, dsp};
    pcIn = pc; testVal = tv; targetVal = tg;
    start = 1'b1;
    repeat (holdCycles) begin
      @(negedge clk);
      pcIn = pcIn + 16'h0100;
    end
    start = 1'b0;
    repeat (7) @(negedge clk);
    check(tag, 16'(doneCount), 16'd1, "done pulse count");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", nextPc, 16'h0000, "reset nextPc");
    check("R1", {13'd0, done, taken, linkWe}, 16'h0000, "reset flags");

    runOp("R2", 19, 8'h04, 16'h0100, 16'h0000, 16'h0, 1);  // jz taken
    runOp("R6", 19, 8'h04, 16'h0100, 16'h0005, 16'h0, 1);  // jz not taken
    runOp("R3", 18, 8'hFD, 16'h0200, 16'h0005, 16'h0, 1);  // jnz, -3
    runOp("R2", 16, 8'h10, 16'h0300, 16'h7FFF, 16'h0, 1);  // pos taken
    runOp("R6", 16, 8'h10, 16'h0300, 16'h8000, 16'h0, 1);  // pos not taken
    runOp("R3", 17, 8'h80, 16'h0010, 16'h8000, 16'h0, 1);  // neg, -128 wrap
    runOp("R3", 19, 8'h7F, 16'hFFF0, 16'h0000, 16'h0, 1);  // +127 wrap
    runOp("R6", 17, 8'h20, 16'h0400, 16'h0001, 16'h0, 1);  // neg not taken
    runOp("R4", 20, 8'h00, 16'h0500, 16'h0000, 16'h1234, 1);
    runOp("R6", 20, 8'h00, 16'h0500, 16'h0001, 16'h1234, 1);
    runOp("R5", 21, 8'h00, 16'h0600, 16'h0000, 16'hBEEF, 1);
    runOp("R5", 21, 8'h00, 16'h0700, 16'h0008, 16'hBEEF, 1);
    runOp("R7", 5,  8'h04, 16'h0800, 16'h0000, 16'h4444, 1);
    runOp("R7", 31, 8'h04, 16'h0900, 16'h0000, 16'h4444, 1);
    runOp("R9", 19, 8'h08, 16'h0A00, 16'h0000, 16'h0, 6);  // start held busy
    runOp("R9", 21, 8'h00, 16'h0B00, 16'h0000, 16'h2222, 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule